// File: doc/BRIEF.md
# Serial Byte Transmitter with Port-Pin Fallback

This block serialises bytes onto a single transmit line. Software writes a byte into a one-entry holding register. When the transmitter is free and a bit-rate tick arrives, the byte moves into a shift register and goes out as a frame. The frame is a low start bit, the data bits least significant first, an optional parity bit, and a high stop bit. Each bit lasts one tick interval. A data-empty flag tells software when the holding register can take the next byte, so frames can run back to back. A done flag shows that the line has gone quiet.

A transmit-enable input switches the pin between two owners. When it is high, the serialiser drives the pin. When it is low, the serialiser is cleared at once, whatever it was doing. The pin then follows two port bits: a direction bit that enables the driver and a data bit that sets its level. Software uses this to hold the line at mark or to force a break.

While any of the receive-side error flags is set, no new frame may start. A frame already on the line finishes normally.

Top module: `serial_tx_port`

## Requirements
- R1: After reset, with transmit-enable low and the port direction bit at 0, `txd_oe` is 0, `txd` is 1, `tx_empty` is 1 and `tx_done` is 1.
- R2: While transmit-enable is low, `txd_oe` equals the port direction bit. When that bit is 1, `txd` equals the port data bit (1 gives mark, 0 gives break). When that bit is 0, `txd` reads 1.
- R3: While transmit-enable is high, `txd_oe` is 1. A frame starts only at a clock where `baud_tick` is 1 and a byte is pending. It sends a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit. Each bit changes only on a `baud_tick` clock, so each lasts one tick interval.
- R4: When `parity_en` is 1 at the start of a frame, a parity bit follows the data bits. For even parity (`parity_odd`=0) it is the XOR of the data bits. For odd parity (`parity_odd`=1) it is the inverse of that XOR.
- R5: A write while enabled sets `tx_empty` to 0 from the next cycle. `tx_empty` returns to 1 in the cycle after the byte is moved into the shift register, which happens at the tick that begins its start bit.
- R6: If a byte is pending when a stop bit ends, its start bit follows at once, with no idle interval.
- R7: `tx_done` falls when a frame starts. It rises at the tick that ends a stop bit with nothing allowed to start. The line is 1 whenever no frame is in flight.
- R8: While any bit of `rx_err` is 1, no frame starts and the pending byte stays pending (`tx_empty`=0). The first tick after the flags clear starts the frame.
- R9: Driving transmit-enable low aborts any frame at the next clock. It also discards the pending byte, so `tx_empty`=1 and `tx_done`=1. When the block is enabled again, the line idles at 1.
- R10: Writes made while transmit-enable is low are ignored: `tx_empty` stays 1, and no frame is sent after the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; low hands the pin to port control |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| parity_en | input | 1 | Append a parity bit to frames |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| port_dat | input | 1 | Port data bit used as pin level while disabled |
| port_dir | input | 1 | Port direction bit used as pin output-enable while disabled |
| rx_err | input | 3 | Receive error flags (overrun, parity, framing); any set blocks frame start |
| baud_tick | input | 1 | One-clock pulse per bit period |
| txd | output | 1 | Transmit pin level |
| txd_oe | output | 1 | Transmit pin output-enable |
| tx_empty | output | 1 | Holding register can take a byte |
| tx_done | output | 1 | No frame in flight and none started |

## Verification
The bench goes after four corner cases.

- **Write at a frame boundary.** It writes a byte just as a stop bit is ending. A design that sampled the holding register late would insert an idle gap, and one that let the new write overwrite the outgoing byte would send the wrong byte.
- **Errors raised while a byte is pending.** It holds the receive error flags high with a byte waiting. A wrong design would start the frame anyway, or would lose the byte when the flags cleared.
- **Disable mid-frame.** It drops the enable in the middle of a data bit. A design without an immediate reset would keep shifting under port control, or would carry a stale byte into the next enable.
- **Both parity senses.** It sends data with an odd and an even number of ones, so an inverted parity sense shows up in the bit after the data.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } tx_phase_e;

    localparam int BYTE_W = 8;
    localparam int ERR_W  = 3;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        tx_phase_e          phase;
        logic [BYTE_W-1:0]  shreg;
        logic [CNT_W-1:0]   bit_idx;
        logic               use_par;
        logic               par_val;
    } tx_frame_t;

    function automatic logic frame_parity(input logic [BYTE_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/tx_holding.sv
module tx_holding
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (take)
                full <= 1'b0;
            if (wr_valid) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

    assert_empty_after_load_R5: assert property (@(posedge clk) disable iff (rst)
        (en && take && !wr_valid) |=> !full);

    assert_disabled_write_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        (!en && wr_valid) |=> !full);

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              pend,
    input  logic [BYTE_W-1:0] hold_data,
    input  logic              err_any,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              take,
    output logic              line,
    output logic              done
);

    tx_frame_t cur, nxt;
    logic      can_load;
    logic      frame_end;

    assign frame_end = (cur.phase == PH_STOP);
    assign can_load  = en && tick && pend && !err_any &&
                       ((cur.phase == PH_IDLE) || frame_end);
    assign take      = can_load;

    always_comb begin
        nxt = cur;
        if (tick) begin
            unique case (cur.phase)
                PH_IDLE, PH_STOP: begin
                    if (can_load) begin
                        nxt.phase   = PH_START;
                        nxt.shreg   = hold_data;
                        nxt.bit_idx = '0;
                        nxt.use_par = par_en;
                        nxt.par_val = frame_parity(hold_data, par_odd);
                    end else begin
                        nxt.phase = PH_IDLE;
                    end
                end
                PH_START: begin
                    nxt.phase   = PH_DATA;
                    nxt.bit_idx = '0;
                end
                PH_DATA: begin
                    nxt.shreg   = cur.shreg >> 1;
                    nxt.bit_idx = cur.bit_idx + 1'b1;
                    if (cur.bit_idx == CNT_W'(BYTE_W - 1))
                        nxt.phase = cur.use_par ? PH_PAR : PH_STOP;
                end
                PH_PAR:  nxt.phase = PH_STOP;
                default: nxt.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cur.phase   <= PH_IDLE;
            cur.shreg   <= '0;
            cur.bit_idx <= '0;
            cur.use_par <= 1'b0;
            cur.par_val <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            done <= 1'b1;
        else if (can_load)
            done <= 1'b0;
        else if (tick && frame_end)
            done <= 1'b1;
    end

    always_comb begin
        unique case (cur.phase)
            PH_START: line = 1'b0;
            PH_DATA:  line = cur.shreg[0];
            PH_PAR:   line = cur.par_val;
            default:  line = 1'b1;
        endcase
    end

    assert_abort_on_disable_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cur.phase == PH_IDLE) && done);

    assert_errors_block_start_R8: assert property (@(posedge clk) disable iff (rst)
        (en && err_any && cur.phase == PH_IDLE) |=> (cur.phase == PH_IDLE));

    assert_bits_move_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cur.phase) && $stable(cur.bit_idx));

    assert_done_line_high_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> line);

    assert_start_follows_load_R6: assert property (@(posedge clk) disable iff (rst)
        can_load |=> (cur.phase == PH_START) && !done);

endmodule

// File: rtl/tx_pin_mux.sv
module tx_pin_mux (
    input  logic en,
    input  logic line,
    input  logic port_dat,
    input  logic port_dir,
    output logic pin,
    output logic pin_oe
);

    always_comb begin
        if (en) begin
            pin    = line;
            pin_oe = 1'b1;
        end else begin
            pin    = port_dir ? port_dat : 1'b1;
            pin_oe = port_dir;
        end
    end

endmodule

// File: rtl/serial_tx_port.sv
module serial_tx_port
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              port_dat,
    input  logic              port_dir,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              baud_tick,
    output logic              txd,
    output logic              txd_oe,
    output logic              tx_empty,
    output logic              tx_done
);

    logic              hold_full;
    logic [BYTE_W-1:0] hold_byte;
    logic              take;
    logic              line;
    logic              err_any;

    assign err_any = |rx_err;

    tx_holding u_hold (
        .clk      (clk),
        .rst      (rst),
        .en       (tx_en),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .full     (hold_full),
        .data     (hold_byte)
    );

    tx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .en        (tx_en),
        .tick      (baud_tick),
        .pend      (hold_full),
        .hold_data (hold_byte),
        .err_any   (err_any),
        .par_en    (parity_en),
        .par_odd   (parity_odd),
        .take      (take),
        .line      (line),
        .done      (tx_done)
    );

    tx_pin_mux u_mux (
        .en       (tx_en),
        .line     (line),
        .port_dat (port_dat),
        .port_dir (port_dir),
        .pin      (txd),
        .pin_oe   (txd_oe)
    );

    assign tx_empty = !hold_full;

    assert_pending_kept_under_error_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_en && err_any && hold_full && !wr_valid) |=> !tx_empty);

endmodule

// File: tb/serial_tx_port_test.sv
module serial_tx_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       port_dat = 1'b0;
    logic       port_dir = 1'b0;
    logic [2:0] rx_err = 3'b000;
    logic       baud_tick = 1'b0;
    logic       txd, txd_oe, tx_empty, tx_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string cur_req = "R1";

    serial_tx_port uut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .wr_valid(wr_valid), .wr_data(wr_data),
        .parity_en(parity_en), .parity_odd(parity_odd), .port_dat(port_dat),
        .port_dir(port_dir), .rx_err(rx_err), .baud_tick(baud_tick),
        .txd(txd), .txd_oe(txd_oe), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bit-rate tick, changed just after the rising edge
    int tick_cnt = 0;
    always @(posedge clk) begin
        #1;
        tick_cnt = (tick_cnt + 1) % TICK_DIV;
        baud_tick = (tick_cnt == 0);
    end

    // behavioural reference model
    bit   q[$];
    bit   m_full = 0;
    bit   m_done = 1;
    int   m_data = 0;

    always @(posedge clk) begin
        if (rst || !tx_en) begin
            q.delete();
            m_full = 0;
            m_done = 1;
        end else begin
            bit was_busy;
            bit loaded;
            loaded = 0;
            was_busy = (q.size() > 0);
            if (baud_tick) begin
                if (q.size() > 0) void'(q.pop_front());
                if (q.size() == 0) begin
                    if (m_full && rx_err == 3'b000) begin
                        int ones;
                        ones = 0;
                        q.push_back(1'b0);
                        for (int i = 0; i < 8; i++) begin
                            q.push_back(m_data[i]);
                            ones += m_data[i];
                        end
                        if (parity_en) q.push_back(((ones % 2) == 1) ^ parity_odd);
                        q.push_back(1'b1);
                        loaded = 1;
                        m_full = 0;
                        m_done = 0;
                    end else if (was_busy) begin
                        m_done = 1;
                    end
                end
            end
            if (wr_valid) begin
                m_full = 1;
                m_data = wr_data;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit e_line, e_txd, e_oe;
            e_line = (q.size() > 0) ? q[0] : 1'b1;
            if (tx_en) begin
                e_txd = e_line; e_oe = 1'b1;
            end else begin
                e_oe = port_dir; e_txd = port_dir ? port_dat : 1'b1;
            end
            check(cur_req, "txd", int'(txd), int'(e_txd));
            check(cur_req, "txd_oe", int'(txd_oe), int'(e_oe));
            check(cur_req, "tx_empty", int'(tx_empty), int'(!m_full));
            check(cur_req, "tx_done", int'(tx_done), int'(m_done));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(posedge clk); #2;
        wr_valid = 1'b1; wr_data = b;
        @(posedge clk); #2;
        wr_valid = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 200 && !tx_empty; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && !tx_done; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        cycles(3);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "txd_oe", int'(txd_oe), 0);
        check("R1", "txd", int'(txd), 1);
        check("R1", "tx_empty", int'(tx_empty), 1);
        check("R1", "tx_done", int'(tx_done), 1);

        // R2: port control while disabled: mark, break, released
        cur_req = "R2";
        @(posedge clk); #2; port_dir = 1'b1; port_dat = 1'b1;
        @(negedge clk); check("R2", "mark txd", int'(txd), 1);
        check("R2", "mark oe", int'(txd_oe), 1);
        @(posedge clk); #2; port_dat = 1'b0;
        @(negedge clk); check("R2", "break txd", int'(txd), 0);
        cycles(5);
        @(posedge clk); #2; port_dir = 1'b0;
        @(negedge clk); check("R2", "released oe", int'(txd_oe), 0);

        // R10: writes while disabled ignored
        cur_req = "R10";
        write_byte(8'h3C);
        @(negedge clk); check("R10", "tx_empty after disabled write", int'(tx_empty), 1);
        @(posedge clk); #2; tx_en = 1'b1;
        cycles(20);
        @(negedge clk); check("R10", "no frame tx_done", int'(tx_done), 1);

        // R3/R5/R7: single frame
        cur_req = "R3";
        write_byte(8'hA5);
        @(negedge clk); check("R5", "tx_empty after write", int'(tx_empty), 0);
        wait_empty();
        cur_req = "R7";
        wait_done();
        cycles(8);
        @(negedge clk); check("R7", "idle line", int'(txd), 1);

        // R6: back-to-back frames
        cur_req = "R6";
        write_byte(8'h01);
        wait_empty();
        write_byte(8'hFE);
        wait_empty();
        write_byte(8'h80);
        wait_done();
        cycles(6);

        // R4: even then odd parity
        cur_req = "R4";
        parity_en = 1'b1; parity_odd = 1'b0;
        write_byte(8'h07);
        wait_done(); cycles(6);
        write_byte(8'h0F);
        wait_done(); cycles(6);
        parity_odd = 1'b1;
        write_byte(8'h07);
        wait_done(); cycles(6);
        write_byte(8'hC3);
        wait_done(); cycles(6);
        parity_en = 1'b0;

        // R8: receive errors block start
        cur_req = "R8";
        rx_err = 3'b010;
        write_byte(8'h5A);
        cycles(30);
        @(negedge clk); check("R8", "pending kept", int'(tx_empty), 0);
        check("R8", "no start", int'(tx_done), 1);
        @(posedge clk); #2; rx_err = 3'b000;
        wait_done(); cycles(4);
        rx_err = 3'b100;
        write_byte(8'h11);
        cycles(12);
        @(posedge clk); #2; rx_err = 3'b000;
        wait_empty(); wait_done(); cycles(6);

        // R9: abort mid-frame with a byte pending
        cur_req = "R9";
        write_byte(8'hF0);
        wait_empty();
        write_byte(8'h99);
        cycles(9);
        @(posedge clk); #2; tx_en = 1'b0; port_dir = 1'b1; port_dat = 1'b0;
        @(negedge clk); check("R9", "break during abort", int'(txd), 0);
        @(posedge clk); #2;
        @(negedge clk); check("R9", "pending discarded", int'(tx_empty), 1);
        check("R9", "done after abort", int'(tx_done), 1);
        @(posedge clk); #2; tx_en = 1'b1;
        cycles(20);
        @(negedge clk); check("R9", "idle after re-enable", int'(txd), 1);
        check("R9", "no stale frame", int'(tx_done), 1);
        write_byte(8'h42);
        wait_done(); cycles(6);

        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule